// File: doc/BRIEF.md
# Display Blink Phase Controller

This block holds the eight-bit feature control byte of a multi-digit display driver and turns it into a display-enable signal that blinks. The byte is written through a strobe that is qualified by a four-bit register address. Only the address nibble 0xE selects the feature byte. The block passes the decode-style bit and the clock-source bit straight to the rest of the chip. It also turns a one-shot "clear the other control registers" request into a single-cycle pulse. The feature byte itself is never affected by that pulse.

Blink timing is measured in ticks of a slow enable, `tick_i`, which is divided down from the system clock elsewhere. One half-period lasts `HALF_TICKS` ticks at the fast rate and twice that at the slow rate. Any write of the feature byte restarts the half-period count at the phase that the byte selects. Several chips can be kept in step with each other: when the sync bit is set, every rising edge of the shared serial load/chip-select line clears the count in the same way.

Top module: `flash_phase_ctrl`

## Requirements
- R1: After a synchronous reset, the feature byte is 0x00. As a result, `disp_on_o`=1, `ctl_rst_o`=0, `hex_mode_o`=0 and `ext_clk_o`=0.
- R2: A cycle with `cfg_we_i`=1 and `cfg_addr_i`=4'hE loads `cfg_wdata_i` into the feature byte. A write to any other address leaves every output unchanged.
- R3: `ext_clk_o` follows bit 0 of the feature byte (1 means an external clock source). `hex_mode_o` follows bit 2 (0 means Code-B decoding, 1 means hexadecimal decoding).
- R4: Writing the byte with bit 1 set drives `ctl_rst_o` high for exactly one cycle, starting on the edge that takes the write. Bit 1 then clears itself. Every other feature bit keeps its written value.
- R5: While bit 4 (blink enable) is 0, `disp_on_o` stays at 1 whatever ticks arrive.
- R6: While bit 4 is 1 and bit 5 (slow rate) is 0, `disp_on_o` inverts once every `HALF_TICKS` ticks. After a write it starts at the value of bit 7 (1 means the display starts on).
- R7: While bit 5 is 1, each half-period lasts 2*`HALF_TICKS` ticks.
- R8: While bit 6 (sync) is 1, a rising edge on `load_i` restarts the half-period count and returns the phase to bit 7. While bit 6 is 0, edges on `load_i` have no effect.
- R9: Every write of the feature byte restarts the half-period count, including a write in the middle of a period.
- R10: Clock cycles without `tick_i` do not advance the blink timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Blink time-base enable, one cycle wide |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address nibble |
| cfg_wdata_i | input | 8 | Register write data |
| load_i | input | 1 | Serial load/chip-select level |
| disp_on_o | output | 1 | Display-enable (blink phase) |
| ctl_rst_o | output | 1 | One-cycle clear for the other control registers |
| hex_mode_o | output | 1 | Decode style: 0 Code-B, 1 hexadecimal |
| ext_clk_o | output | 1 | Clock source: 0 internal, 1 serial clock pin |

## Verification
Several properties are checked on every cycle. The clear pulse never lasts more than one cycle. The half-period counter stays within the slow-rate bound. The timing registers hold still when no tick and no restart arrive. A restart always lands on count zero with the requested phase. Writes to foreign addresses disturb no stored bit. The number of ticks that separate phase flips at each rate, and the way a sync edge or a rewrite shifts the following flip, cannot be seen from one cycle to the next. Those are shown by the bench's directed sequences and by its random run against a cycle model.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam int unsigned   ADDR_W    = 4;
    localparam logic [3:0]    FEAT_ADDR = 4'hE;

    // Feature byte, packed MSB first so field positions match the write data.
    typedef struct packed {
        logic start_on;   // bit 7: blink begins with display on
        logic sync_load;  // bit 6: load rising edge restarts timing
        logic slow_rate;  // bit 5: doubled half-period
        logic blink;      // bit 4: blink enable
        logic serial_on;  // bit 3: serial interface enable
        logic hex;        // bit 2: hexadecimal decode
        logic ctl_clear;  // bit 1: self-clearing control reset
        logic ext_clk;    // bit 0: external clock source
    } feat_t;

    localparam feat_t FEAT_RESET = '0;

    // Ticks in one half-period at the selected rate.
    function automatic int unsigned half_limit(input int unsigned base, input logic slow);
        return slow ? 2 * base : base;
    endfunction

endpackage

// File: rtl/flash_cfg_reg.sv
module flash_cfg_reg
    import flash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output feat_t             feat_o,
    output logic              wr_hit_o,
    output logic              ctl_rst_o
);

    feat_t feat_q;

    assign wr_hit_o = we_i && (addr_i == FEAT_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            feat_q <= FEAT_RESET;
        end else if (wr_hit_o) begin
            feat_q <= feat_t'(wdata_i);
        end else begin
            feat_q.ctl_clear <= 1'b0;
        end
    end

    assign feat_o    = feat_q;
    assign ctl_rst_o = feat_q.ctl_clear;

    // R4: pulse lasts a single cycle unless rewritten
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_rst_o && !wr_hit_o) |=> !ctl_rst_o);

    // R4: a write carrying the clear bit raises the pulse
    p_pulse_from_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_hit_o && wdata_i[1]) |=> ctl_rst_o);

    // R2: foreign addresses leave stored bits alone
    p_foreign_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i != FEAT_ADDR) |=> ($stable(feat_q[7:2]) && $stable(feat_q.ext_clk)));

endmodule

// File: rtl/flash_edge_det.sv
module flash_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);

    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i && !lvl_q;

    // R8: a detected edge is never reported on two cycles in a row
    p_rise_isolated_r8: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/flash_phase_gen.sv
module flash_phase_gen #(
    parameter int unsigned HALF_TICKS = 8,
    parameter int unsigned CNT_W      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic restart_i,
    input  logic start_i,
    input  logic slow_i,
    output logic phase_o
);

    localparam int unsigned LIM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic [LIM_W-1:0] last_idx;

    assign last_idx = LIM_W'(flash_pkg::half_limit(HALF_TICKS, slow_i) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q   <= '0;
            phase_q <= start_i;
        end else if (tick_i) begin
            if (LIM_W'(cnt_q) >= last_idx) begin
                cnt_q   <= '0;
                phase_q <= !phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;

    // R7: count never exceeds the longest half-period
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (LIM_W'(cnt_q) < LIM_W'(2 * HALF_TICKS)));

    // R10: without tick or restart the timing state is frozen
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_i) |=> ($stable(cnt_q) && $stable(phase_q)));

    // R9: a restart lands on count zero with the requested phase
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (cnt_q == '0 && phase_q == $past(start_i)));

endmodule

// File: rtl/flash_phase_ctrl.sv
module flash_phase_ctrl
    import flash_pkg::*;
#(
    parameter int unsigned HALF_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        cfg_we_i,
    input  logic [3:0]  cfg_addr_i,
    input  logic [7:0]  cfg_wdata_i,
    input  logic        load_i,
    output logic        disp_on_o,
    output logic        ctl_rst_o,
    output logic        hex_mode_o,
    output logic        ext_clk_o
);

    localparam int unsigned CNT_W = (2 * HALF_TICKS > 2) ? $clog2(2 * HALF_TICKS) : 1;

    feat_t feat;
    logic  wr_hit;
    logic  load_rise;
    logic  restart;
    logic  start_val;
    logic  phase;

    flash_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .feat_o    (feat),
        .wr_hit_o  (wr_hit),
        .ctl_rst_o (ctl_rst_o)
    );

    flash_edge_det u_load_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (load_i),
        .rise_o (load_rise)
    );

    // A write wins over a sync edge in the same cycle.
    assign restart   = wr_hit || (feat.sync_load && load_rise);
    assign start_val = wr_hit ? cfg_wdata_i[7] : feat.start_on;

    flash_phase_gen #(
        .HALF_TICKS (HALF_TICKS),
        .CNT_W      (CNT_W)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .restart_i (restart),
        .start_i   (start_val),
        .slow_i    (feat.slow_rate),
        .phase_o   (phase)
    );

    assign disp_on_o  = feat.blink ? phase : 1'b1;
    assign hex_mode_o = feat.hex;
    assign ext_clk_o  = feat.ext_clk;

    // R8: with sync off, a load edge alone causes no restart
    p_nosync_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!feat.sync_load && !wr_hit) |-> !restart);

endmodule

// File: tb/flash_phase_ctrl_bench.sv
module flash_phase_ctrl_bench;

    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [3:0] cfg_addr_i = 4'h0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic       load_i = 1'b0;
    logic       disp_on_o, ctl_rst_o, hex_mode_o, ext_clk_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // model state
    logic [7:0] m_cfg = 8'h00;
    int         m_cnt = 0;
    logic       m_ph = 1'b0;
    logic       m_ld = 1'b0;

    always #5 clk = ~clk;

    flash_phase_ctrl #(.HALF_TICKS(H)) u_flash_phase_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
        .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .load_i(load_i),
        .disp_on_o(disp_on_o), .ctl_rst_o(ctl_rst_o),
        .hex_mode_o(hex_mode_o), .ext_clk_o(ext_clk_o)
    );

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    function automatic logic exp_disp();
        return m_cfg[4] ? m_ph : 1'b1;
    endfunction

    task automatic model_update(input logic we, input logic [3:0] a, input logic [7:0] d,
                                input logic ld, input logic tk);
        logic hit, rise;
        int   lim;
        hit  = we && (a == 4'hE);
        rise = ld && !m_ld;
        m_ld = ld;
        lim  = m_cfg[5] ? 2 * H : H;
        if (hit) begin
            m_cnt = 0; m_ph = d[7];
        end else if (m_cfg[6] && rise) begin
            m_cnt = 0; m_ph = m_cfg[7];
        end else if (tk) begin
            if (m_cnt == lim - 1) begin m_cnt = 0; m_ph = !m_ph; end
            else m_cnt++;
        end
        if (hit) m_cfg = d;
        else     m_cfg[1] = 1'b0;
    endtask

    // Drive at negedge, model the posedge, compare at the next negedge.
    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic ld, input logic tk);
        cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = d; load_i = ld; tick_i = tk;
        @(posedge clk);
        model_update(we, a, d, ld, tk);
        @(negedge clk);
        cfg_we_i = 1'b0; tick_i = 1'b0;
        chk(cur_tag, "disp_on_o", disp_on_o, exp_disp());
        chk(cur_tag, "ctl_rst_o", ctl_rst_o, m_cfg[1]);
        chk(cur_tag, "hex_mode_o", hex_mode_o, m_cfg[2]);
        chk(cur_tag, "ext_clk_o", ext_clk_o, m_cfg[0]);
    endtask

    task automatic wr(input logic [7:0] d);
        step(1'b1, 4'hE, d, load_i, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, load_i, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, load_i, 1'b0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cur_tag = "R1";
        chk("R1", "disp_on_o", disp_on_o, 1'b1);
        chk("R1", "ctl_rst_o", ctl_rst_o, 1'b0);
        chk("R1", "hex_mode_o", hex_mode_o, 1'b0);
        chk("R1", "ext_clk_o", ext_clk_o, 1'b0);

        // R3 mode bits, R2 foreign address ignored
        cur_tag = "R3";
        wr(8'h05);
        chk("R3", "hex_mode_o", hex_mode_o, 1'b1);
        chk("R3", "ext_clk_o", ext_clk_o, 1'b1);
        cur_tag = "R2";
        step(1'b1, 4'h3, 8'hFF, 1'b0, 1'b0);
        chk("R2", "hex_mode_o", hex_mode_o, 1'b1);
        chk("R2", "disp_on_o", disp_on_o, 1'b1);
        chk("R2", "ctl_rst_o", ctl_rst_o, 1'b0);

        // R4 self-clearing pulse
        cur_tag = "R4";
        wr(8'h06);
        chk("R4", "ctl_rst_o", ctl_rst_o, 1'b1);
        idle(1);
        chk("R4", "ctl_rst_o", ctl_rst_o, 1'b0);
        chk("R4", "hex_mode_o", hex_mode_o, 1'b1);

        // R5 no blinking when disabled
        cur_tag = "R5";
        wr(8'h00);
        ticks(3 * H);
        chk("R5", "disp_on_o", disp_on_o, 1'b1);

        // R6 fast rate, start phase
        cur_tag = "R6";
        wr(8'h10);
        chk("R6", "disp_on_o", disp_on_o, 1'b0);
        ticks(H - 1);
        chk("R6", "disp_on_o", disp_on_o, 1'b0);
        ticks(1);
        chk("R6", "disp_on_o", disp_on_o, 1'b1);
        ticks(H);
        chk("R6", "disp_on_o", disp_on_o, 1'b0);
        wr(8'h90);
        chk("R6", "disp_on_o", disp_on_o, 1'b1);

        // R7 slow rate
        cur_tag = "R7";
        wr(8'h30);
        ticks(2 * H - 1);
        chk("R7", "disp_on_o", disp_on_o, 1'b0);
        ticks(1);
        chk("R7", "disp_on_o", disp_on_o, 1'b1);

        // R10 idle clocks do not advance
        cur_tag = "R10";
        wr(8'h10);
        ticks(H - 1);
        idle(20);
        chk("R10", "disp_on_o", disp_on_o, 1'b0);
        ticks(1);
        chk("R10", "disp_on_o", disp_on_o, 1'b1);

        // R9 rewrite mid-period restarts
        cur_tag = "R9";
        wr(8'h10);
        ticks(2);
        wr(8'h10);
        ticks(H - 1);
        chk("R9", "disp_on_o", disp_on_o, 1'b0);
        ticks(1);
        chk("R9", "disp_on_o", disp_on_o, 1'b1);

        // R8 sync on load edge, and no effect with sync off
        cur_tag = "R8";
        wr(8'h50);
        ticks(2);
        step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
        ticks(H - 1);
        chk("R8", "disp_on_o", disp_on_o, 1'b0);
        ticks(1);
        chk("R8", "disp_on_o", disp_on_o, 1'b1);
        wr(8'h10);
        ticks(2);
        step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
        ticks(H - 2);
        chk("R8", "disp_on_o", disp_on_o, 1'b1);

        // Random mix against the model
        cur_tag = "R6";
        for (int i = 0; i < 4000; i++) begin
            logic       we, ld, tk;
            logic [3:0] a;
            logic [7:0] d;
            we = ($urandom_range(0, 39) == 0);
            a  = ($urandom_range(0, 3) != 0) ? 4'hE : 4'($urandom_range(0, 15));
            d  = 8'($urandom);
            ld = ($urandom_range(0, 7) == 0) ? !load_i : load_i;
            tk = ($urandom_range(0, 1) == 1);
            step(we, a, d, ld, tk);
        end

        finish_run();
    end

endmodule